// File: doc/BRIEF.md
# Protection Fault Latch with Timestamping

This block gathers the fault lines of a machine-protection system and turns them into two permit outputs. Each input is enabled or ignored according to a per-beam-mode mask. The mask is taken up only when a cycle-start marker arrives, so it never changes partway through a machine cycle. Every fresh trip is reported as a one-cycle event. The event carries the set of sources that tripped and their time within the current machine cycle, counted in link-clock periods.

The block keeps a record of which source tripped first and when. That record is held until an operator re-arm. The block also generates two faults of its own. One is raised when the cycle-start heartbeat stops arriving. The other is raised when successive timestamps received over the timing link step by an implausible amount.

There are two permit outputs. The auto-reset permit returns by itself once all enabled faults have been clear for a programmable holdoff. The latched permit comes back only when an explicit re-arm is given while no fault is present.

Top module: `prot_fault_latch`

## Requirements
- R1: While reset is held, both permits, `trip_valid_o`, `first_valid_o`, `hb_fault_o` and `ts_fault_o` are 0.
- R2: An enabled source that was inactive on the previous clock edge and is active on this edge is a new trip. One edge later `trip_valid_o` pulses high for one cycle and `trip_vec_o` has that source's bit set. `trip_time_o` then holds the number of clock edges since the edge that sampled `cycle_start_i`, which is 0 when the trip and the cycle start share an edge.
- R3: When several sources trip on the same edge, the lowest-numbered one is recorded as first. `first_valid_o`, `first_id_o` and `first_time_o` keep that record, unchanged by later trips, until a re-arm is accepted.
- R4: Input i is enabled when bit `mode*N_IN+i` of `MODE_MASKS` is 1, where mode is the beam mode. Mode 0 applies after reset. `beam_mode_i` is sampled only on an edge where `cycle_start_i` is 1, and the new mask takes effect on the following edge. A disabled input causes no trip, no permit drop and no status bit.
- R5: After `HB_LIMIT` consecutive edges without `cycle_start_i`, `hb_fault_o` goes high. It then acts as fault source `N_IN`, which is always enabled. The next edge that sees `cycle_start_i` clears it.
- R6: On each edge where `link_time_valid_i` is 1, every value after the first one since reset is compared with the previous one. If the modulo difference is 0 or greater than `MAX_STEP`, `ts_fault_o` is set. `ts_fault_o` is fault source `N_IN+1`, which is always enabled, and it stays set until a received value steps by 1 to `MAX_STEP`.
- R7: `permit_auto_o` is 0 on the edge after any enabled source is active. It rises on the edge after `holdoff_i+1` consecutive edges that see no active source. A fault during the holdoff restarts the count.
- R8: `permit_latch_o` drops with any active source. It rises only on an edge that sees `rearm_i` with no active source. That edge also clears the first-trip record. A re-arm while a fault is active is ignored.
- R9: `fault_active_o` shows, one edge late, the set of enabled sources that are currently active.
- R10: The within-cycle trip time saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_i | input | N_IN | Raw fault lines, high = fault |
| beam_mode_i | input | MODE_W | Requested beam mode, taken at cycle start |
| cycle_start_i | input | 1 | One-cycle cycle-start marker from the timing decoder |
| link_time_valid_i | input | 1 | Strobe for a received link timestamp |
| link_time_i | input | LINK_W | Received link timestamp |
| holdoff_i | input | HOLD_W | Clear edges required before the auto permit returns, minus one |
| rearm_i | input | 1 | Operator re-arm of the latched permit |
| permit_auto_o | output | 1 | Auto-reset permit |
| permit_latch_o | output | 1 | Latched permit |
| trip_valid_o | output | 1 | One-cycle trip event |
| trip_vec_o | output | N_IN+2 | Sources that newly tripped |
| trip_time_o | output | TS_W | Within-cycle time of the last trip event |
| first_valid_o | output | 1 | First-trip record is held |
| first_id_o | output | ID_W | Index of the first source to trip |
| first_time_o | output | TS_W | Within-cycle time of the first trip |
| fault_active_o | output | N_IN+2 | Enabled sources active on the last edge |
| hb_fault_o | output | 1 | Heartbeat missing |
| ts_fault_o | output | 1 | Implausible link timestamp step |

## Verification
Raw input trips, re-arms and mask changes show on the outputs one edge after the edge that samples them. The heartbeat and timestamp faults show on their status pins one edge after the deciding edge, and their trip events follow one edge later still. The auto permit returns `holdoff_i+1` edges after the first clear edge. The bench drives every input on a falling edge and samples on the next falling edge, after exactly the number of rising edges counted above. It also samples one edge early in the holdoff and heartbeat cases, to show that the output has not yet moved.

// File: rtl/pfl_pkg.sv
// Shared constants and types for the protection fault latch.
// Assumes internal fault sources are appended after the external inputs.
package pfl_pkg;
    localparam int unsigned INT_SRC_CNT = 2;   // heartbeat + link timestamp check
    localparam int unsigned HB_SRC_OFS  = 0;   // heartbeat fault position among internal sources
    localparam int unsigned TS_SRC_OFS  = 1;   // timestamp fault position among internal sources

    typedef enum logic {
        PERMIT_DOWN = 1'b0,
        PERMIT_UP   = 1'b1
    } permit_e;
endpackage

// File: rtl/pfl_cycle_timer.sv
// Within-cycle time counter and cycle-start heartbeat watchdog.
// Assumes cycle_start_i is a single-cycle pulse in the clk domain.
// The time counter saturates; the watchdog counter saturates at HB_LIMIT.
module pfl_cycle_timer #(
    parameter int unsigned TS_W     = 20,
    parameter int unsigned HB_LIMIT = 338000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cycle_start_i,
    output logic [TS_W-1:0] time_now_o,
    output logic            hb_miss_o
);
    localparam int unsigned      HB_W   = $clog2(HB_LIMIT + 1);
    localparam logic [TS_W-1:0]  TS_MAX = '1;
    localparam logic [HB_W-1:0]  HB_LIM = HB_W'(HB_LIMIT);

    logic [TS_W-1:0] cyc_cnt_q;
    logic [HB_W-1:0] hb_cnt_q;

    // Count link clocks since the last cycle start, saturating at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt_q <= '0;
        end else if (cycle_start_i) begin
            cyc_cnt_q <= TS_W'(1);
        end else if (cyc_cnt_q != TS_MAX) begin
            cyc_cnt_q <= cyc_cnt_q + 1'b1;
        end
    end

    // Count clocks without a heartbeat, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_cnt_q <= '0;
        end else if (cycle_start_i) begin
            hb_cnt_q <= '0;
        end else if (hb_cnt_q != HB_LIM) begin
            hb_cnt_q <= hb_cnt_q + 1'b1;
        end
    end

    assign time_now_o = cycle_start_i ? '0 : cyc_cnt_q;
    assign hb_miss_o  = (hb_cnt_q == HB_LIM);
endmodule

// File: rtl/pfl_stamp_check.sv
// Plausibility check on successive link timestamps.
// A value must step by 1..MAX_STEP (modulo 2**LINK_W) from the previous one.
// The first value after reset is accepted; the flag holds until a good step.
module pfl_stamp_check #(
    parameter int unsigned LINK_W   = 32,
    parameter int unsigned MAX_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [LINK_W-1:0] value_i,
    output logic              bad_o
);
    localparam logic [LINK_W-1:0] STEP_LIM = LINK_W'(MAX_STEP);

    logic [LINK_W-1:0] prev_q;
    logic [LINK_W-1:0] step;
    logic              seen_q;
    logic              bad_q;

    assign step = value_i - prev_q;

    // Remember each received value and judge its step from the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (valid_i) begin
            prev_q <= value_i;
            seen_q <= 1'b1;
            bad_q  <= seen_q && ((step == '0) || (step > STEP_LIM));
        end
    end

    assign bad_o = bad_q;
endmodule

// File: rtl/pfl_trip_capture.sv
// Masks fault sources by beam mode, detects new trips, stamps them and
// keeps the first-trip record. External inputs occupy indices 0..N_IN-1,
// internal sources follow and are never masked. Lowest index wins ties.
module pfl_trip_capture #(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned MODE_W = 2,
    parameter logic [(2**MODE_W)*N_IN-1:0] MODE_MASKS = '1,
    parameter int unsigned TS_W   = 20,
    parameter int unsigned N_SRC  = N_IN + pfl_pkg::INT_SRC_CNT,
    parameter int unsigned ID_W   = $clog2(N_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cycle_start_i,
    input  logic [MODE_W-1:0]               beam_mode_i,
    input  logic [N_IN-1:0]                 fault_i,
    input  logic [pfl_pkg::INT_SRC_CNT-1:0] int_fault_i,
    input  logic [TS_W-1:0]                 time_now_i,
    input  logic                            rearm_i,
    output logic                            any_active_o,
    output logic                            trip_valid_o,
    output logic [N_SRC-1:0]                trip_vec_o,
    output logic [TS_W-1:0]                 trip_time_o,
    output logic                            first_valid_o,
    output logic [ID_W-1:0]                 first_id_o,
    output logic [TS_W-1:0]                 first_time_o,
    output logic [N_SRC-1:0]                fault_active_o
);
    logic [N_IN-1:0]  mask_q;
    logic [N_SRC-1:0] raw_src;
    logic [N_SRC-1:0] src_en;
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] new_trip;
    logic [ID_W-1:0]  first_idx;
    logic             clear_first;

    // Route each source and its enable: masked inputs, then always-on internals.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_IN) begin : g_ext
            assign raw_src[g] = fault_i[g];
            assign src_en[g]  = mask_q[g];
        end else begin : g_int
            assign raw_src[g] = int_fault_i[g - N_IN];
            assign src_en[g]  = 1'b1;
        end
    end

    assign active       = raw_src & src_en;
    assign new_trip     = active & ~fault_active_o;
    assign any_active_o = |active;
    assign clear_first  = rearm_i && !any_active_o;

    // Load the beam-mode mask only at cycle-start boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MODE_MASKS[N_IN-1:0];
        end else if (cycle_start_i) begin
            mask_q <= MODE_MASKS[int'(beam_mode_i)*N_IN +: N_IN];
        end
    end

    // Pick the lowest-numbered source among the new trips.
    always_comb begin
        first_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (new_trip[i]) begin
                first_idx = ID_W'(i);
            end
        end
    end

    // Register the trip event, its timestamp and the active-source status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_active_o <= '0;
            trip_valid_o   <= 1'b0;
            trip_vec_o     <= '0;
            trip_time_o    <= '0;
        end else begin
            fault_active_o <= active;
            trip_valid_o   <= |new_trip;
            trip_vec_o     <= new_trip;
            if (|new_trip) begin
                trip_time_o <= time_now_i;
            end
        end
    end

    // Hold the first trip until a re-arm is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_valid_o <= 1'b0;
            first_id_o    <= '0;
            first_time_o  <= '0;
        end else if (clear_first) begin
            first_valid_o <= 1'b0;
        end else if (|new_trip && !first_valid_o) begin
            first_valid_o <= 1'b1;
            first_id_o    <= first_idx;
            first_time_o  <= time_now_i;
        end
    end
endmodule

// File: rtl/pfl_permit.sv
// Auto-reset and latched permit generation.
// Assumes any_active_i is the combined enabled-fault level for this cycle.
// Both permits come up low after reset.
module pfl_permit #(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_active_i,
    input  logic              rearm_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              permit_auto_o,
    output logic              permit_latch_o
);
    import pfl_pkg::*;

    permit_e           auto_q;
    permit_e           latch_q;
    logic [HOLD_W-1:0] hold_cnt_q;

    // Drop on fault; return after holdoff_i+1 clear edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q     <= PERMIT_DOWN;
            hold_cnt_q <= '0;
        end else if (any_active_i) begin
            auto_q     <= PERMIT_DOWN;
            hold_cnt_q <= '0;
        end else if (auto_q == PERMIT_DOWN) begin
            if (hold_cnt_q >= holdoff_i) begin
                auto_q <= PERMIT_UP;
            end else begin
                hold_cnt_q <= hold_cnt_q + 1'b1;
            end
        end
    end

    // Drop on fault; return only on a re-arm with no fault present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= PERMIT_DOWN;
        end else if (any_active_i) begin
            latch_q <= PERMIT_DOWN;
        end else if (rearm_i) begin
            latch_q <= PERMIT_UP;
        end
    end

    assign permit_auto_o  = (auto_q == PERMIT_UP);
    assign permit_latch_o = (latch_q == PERMIT_UP);
endmodule

// File: rtl/prot_fault_latch.sv
// Machine-protection fault concentrator: beam-mode masking, per-trip
// within-cycle timestamps, first-trip record, heartbeat and link timestamp
// checks, auto-reset and latched permits. All inputs are synchronous to clk.
module prot_fault_latch #(
    parameter int unsigned N_IN     = 8,
    parameter int unsigned MODE_W   = 2,
    parameter logic [(2**MODE_W)*N_IN-1:0] MODE_MASKS = '1,
    parameter int unsigned TS_W     = 20,
    parameter int unsigned HB_LIMIT = 338000,
    parameter int unsigned LINK_W   = 32,
    parameter int unsigned MAX_STEP = 2,
    parameter int unsigned HOLD_W   = 8,
    localparam int unsigned N_SRC   = N_IN + pfl_pkg::INT_SRC_CNT,
    localparam int unsigned ID_W    = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   fault_i,
    input  logic [MODE_W-1:0] beam_mode_i,
    input  logic              cycle_start_i,
    input  logic              link_time_valid_i,
    input  logic [LINK_W-1:0] link_time_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    input  logic              rearm_i,
    output logic              permit_auto_o,
    output logic              permit_latch_o,
    output logic              trip_valid_o,
    output logic [N_SRC-1:0]  trip_vec_o,
    output logic [TS_W-1:0]   trip_time_o,
    output logic              first_valid_o,
    output logic [ID_W-1:0]   first_id_o,
    output logic [TS_W-1:0]   first_time_o,
    output logic [N_SRC-1:0]  fault_active_o,
    output logic              hb_fault_o,
    output logic              ts_fault_o
);
    logic [TS_W-1:0]                 time_now;
    logic                            hb_miss;
    logic                            ts_bad;
    logic                            any_active;
    logic [pfl_pkg::INT_SRC_CNT-1:0] int_fault;

    assign int_fault[pfl_pkg::HB_SRC_OFS] = hb_miss;
    assign int_fault[pfl_pkg::TS_SRC_OFS] = ts_bad;
    assign hb_fault_o = hb_miss;
    assign ts_fault_o = ts_bad;

    pfl_cycle_timer #(
        .TS_W     (TS_W),
        .HB_LIMIT (HB_LIMIT)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cycle_start_i (cycle_start_i),
        .time_now_o    (time_now),
        .hb_miss_o     (hb_miss)
    );

    pfl_stamp_check #(
        .LINK_W   (LINK_W),
        .MAX_STEP (MAX_STEP)
    ) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (link_time_valid_i),
        .value_i (link_time_i),
        .bad_o   (ts_bad)
    );

    pfl_trip_capture #(
        .N_IN       (N_IN),
        .MODE_W     (MODE_W),
        .MODE_MASKS (MODE_MASKS),
        .TS_W       (TS_W),
        .N_SRC      (N_SRC),
        .ID_W       (ID_W)
    ) u_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .cycle_start_i  (cycle_start_i),
        .beam_mode_i    (beam_mode_i),
        .fault_i        (fault_i),
        .int_fault_i    (int_fault),
        .time_now_i     (time_now),
        .rearm_i        (rearm_i),
        .any_active_o   (any_active),
        .trip_valid_o   (trip_valid_o),
        .trip_vec_o     (trip_vec_o),
        .trip_time_o    (trip_time_o),
        .first_valid_o  (first_valid_o),
        .first_id_o     (first_id_o),
        .first_time_o   (first_time_o),
        .fault_active_o (fault_active_o)
    );

    pfl_permit #(
        .HOLD_W (HOLD_W)
    ) u_permit (
        .clk            (clk),
        .rst_n          (rst_n),
        .any_active_i   (any_active),
        .rearm_i        (rearm_i),
        .holdoff_i      (holdoff_i),
        .permit_auto_o  (permit_auto_o),
        .permit_latch_o (permit_latch_o)
    );
endmodule

// File: rtl/pfl_checker.sv
// Temporal checks on the fault latch ports, bound into every instance.
module pfl_checker #(
    parameter int unsigned N_SRC = 10,
    parameter int unsigned ID_W  = 4,
    parameter int unsigned TS_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cycle_start_i,
    input logic             rearm_i,
    input logic             permit_auto_o,
    input logic             permit_latch_o,
    input logic             trip_valid_o,
    input logic             first_valid_o,
    input logic [ID_W-1:0]  first_id_o,
    input logic [TS_W-1:0]  first_time_o,
    input logic [N_SRC-1:0] fault_active_o,
    input logic             hb_fault_o
);
    // R7: a trip event is never seen with the auto permit still up
    a_r7_trip_drops_auto: assert property (@(posedge clk) disable iff (!rst_n)
        trip_valid_o |-> !permit_auto_o);

    // R8: a trip event is never seen with the latched permit still up
    a_r8_trip_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
        trip_valid_o |-> !permit_latch_o);

    // R8: the latched permit only rises after a re-arm
    a_r8_latch_needs_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(permit_latch_o) |-> $past(rearm_i));

    // R3: the first-trip record holds until re-armed
    a_r3_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (first_valid_o && !rearm_i) |=>
            (first_valid_o && $stable(first_id_o) && $stable(first_time_o)));

    // R7: the auto permit only returns with no active source
    a_r7_auto_rises_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(permit_auto_o) |-> (fault_active_o == '0));

    // R5: a cycle start clears the heartbeat fault
    a_r5_start_clears_hb: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_i |=> !hb_fault_o);
endmodule

bind prot_fault_latch pfl_checker #(
    .N_SRC (N_SRC),
    .ID_W  (ID_W),
    .TS_W  (TS_W)
) u_pfl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cycle_start_i  (cycle_start_i),
    .rearm_i        (rearm_i),
    .permit_auto_o  (permit_auto_o),
    .permit_latch_o (permit_latch_o),
    .trip_valid_o   (trip_valid_o),
    .first_valid_o  (first_valid_o),
    .first_id_o     (first_id_o),
    .first_time_o   (first_time_o),
    .fault_active_o (fault_active_o),
    .hb_fault_o     (hb_fault_o)
);

// File: tb/tb_prot_fault_latch.sv
// Directed bench for the protection fault latch; one task per scenario.
module tb_prot_fault_latch;
    localparam int unsigned N_IN     = 4;
    localparam int unsigned MODE_W   = 1;
    localparam int unsigned TS_W     = 8;
    localparam int unsigned HB_LIMIT = 1000;
    localparam int unsigned LINK_W   = 16;
    localparam int unsigned MAX_STEP = 4;
    localparam int unsigned HOLD_W   = 4;
    localparam int unsigned N_SRC    = N_IN + 2;
    localparam int unsigned ID_W     = $clog2(N_SRC);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_IN-1:0]   fault_i = '0;
    logic [MODE_W-1:0] beam_mode_i = '0;
    logic              cycle_start_i = 1'b0;
    logic              link_time_valid_i = 1'b0;
    logic [LINK_W-1:0] link_time_i = '0;
    logic [HOLD_W-1:0] holdoff_i = '0;
    logic              rearm_i = 1'b0;
    logic              permit_auto_o, permit_latch_o, trip_valid_o, first_valid_o;
    logic              hb_fault_o, ts_fault_o;
    logic [N_SRC-1:0]  trip_vec_o, fault_active_o;
    logic [TS_W-1:0]   trip_time_o, first_time_o;
    logic [ID_W-1:0]   first_id_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prot_fault_latch #(
        .N_IN(N_IN), .MODE_W(MODE_W), .MODE_MASKS(8'b0101_1111), .TS_W(TS_W),
        .HB_LIMIT(HB_LIMIT), .LINK_W(LINK_W), .MAX_STEP(MAX_STEP), .HOLD_W(HOLD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .beam_mode_i(beam_mode_i),
        .cycle_start_i(cycle_start_i), .link_time_valid_i(link_time_valid_i),
        .link_time_i(link_time_i), .holdoff_i(holdoff_i), .rearm_i(rearm_i),
        .permit_auto_o(permit_auto_o), .permit_latch_o(permit_latch_o),
        .trip_valid_o(trip_valid_o), .trip_vec_o(trip_vec_o), .trip_time_o(trip_time_o),
        .first_valid_o(first_valid_o), .first_id_o(first_id_o), .first_time_o(first_time_o),
        .fault_active_o(fault_active_o), .hb_fault_o(hb_fault_o), .ts_fault_o(ts_fault_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_cycle();
        cycle_start_i = 1'b1;
        @(negedge clk);
        cycle_start_i = 1'b0;
    endtask

    task automatic rearm();
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
    endtask

    // R1: state while reset is held
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 permit_auto", 32'(permit_auto_o), 0);
        chk("R1 permit_latch", 32'(permit_latch_o), 0);
        chk("R1 trip_valid", 32'(trip_valid_o), 0);
        chk("R1 first_valid", 32'(first_valid_o), 0);
        chk("R1 hb/ts fault", 32'({hb_fault_o, ts_fault_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 auto up after reset", 32'(permit_auto_o), 1);
        rearm();
        chk("R8 latch up on rearm", 32'(permit_latch_o), 1);
    endtask

    // R2 R9 R7 R8: basic trip with timestamp
    task automatic t_trip_time();
        start_cycle();
        repeat (4) @(negedge clk);
        fault_i = 4'b0010;
        @(negedge clk);
        chk("R2 trip_valid", 32'(trip_valid_o), 1);
        chk("R2 trip_vec", 32'(trip_vec_o), 32'b000010);
        chk("R2 trip_time", 32'(trip_time_o), 5);
        chk("R9 fault_active", 32'(fault_active_o), 32'b000010);
        chk("R7 auto down", 32'(permit_auto_o), 0);
        chk("R8 latch down", 32'(permit_latch_o), 0);
        @(negedge clk);
        chk("R2 trip pulse ends", 32'(trip_valid_o), 0);
        fault_i = '0;
        @(negedge clk);
        chk("R7 auto back, holdoff 0", 32'(permit_auto_o), 1);
        chk("R8 latch stays down", 32'(permit_latch_o), 0);
        rearm();
        chk("R8 latch up after rearm", 32'(permit_latch_o), 1);
        chk("R8 first cleared", 32'(first_valid_o), 0);
        // R2: trip on the cycle-start edge gets time 0
        cycle_start_i = 1'b1;
        fault_i = 4'b1000;
        @(negedge clk);
        cycle_start_i = 1'b0;
        chk("R2 time 0 at start", 32'(trip_time_o), 0);
        fault_i = '0;
        @(negedge clk);
        rearm();
    endtask

    // R3 R8: first trip among simultaneous trips, rearm rules
    task automatic t_first();
        start_cycle();
        repeat (2) @(negedge clk);
        fault_i = 4'b1100;
        @(negedge clk);
        chk("R3 trip_vec", 32'(trip_vec_o), 32'b001100);
        chk("R3 first_valid", 32'(first_valid_o), 1);
        chk("R3 first_id lowest", 32'(first_id_o), 2);
        chk("R3 first_time", 32'(first_time_o), 3);
        fault_i = 4'b1101;
        @(negedge clk);
        chk("R3 later trip vec", 32'(trip_vec_o), 32'b000001);
        chk("R3 first_id held", 32'(first_id_o), 2);
        chk("R3 first_time held", 32'(first_time_o), 3);
        rearm();
        chk("R8 rearm under fault ignored", 32'(permit_latch_o), 0);
        chk("R8 first kept under fault", 32'(first_valid_o), 1);
        fault_i = '0;
        @(negedge clk);
        rearm();
        chk("R8 latch up", 32'(permit_latch_o), 1);
        chk("R8 first cleared", 32'(first_valid_o), 0);
    endtask

    // R7: holdoff count and restart
    task automatic t_holdoff();
        holdoff_i = 4'd3;
        start_cycle();
        fault_i = 4'b0001;
        @(negedge clk);
        fault_i = '0;
        repeat (3) @(negedge clk);
        chk("R7 auto still down in holdoff", 32'(permit_auto_o), 0);
        @(negedge clk);
        chk("R7 auto up after holdoff", 32'(permit_auto_o), 1);
        fault_i = 4'b0001;
        @(negedge clk);
        fault_i = '0;
        @(negedge clk);
        fault_i = 4'b0001;
        @(negedge clk);
        fault_i = '0;
        repeat (3) @(negedge clk);
        chk("R7 restart after refault", 32'(permit_auto_o), 0);
        @(negedge clk);
        chk("R7 auto up after restart", 32'(permit_auto_o), 1);
        holdoff_i = '0;
        rearm();
    endtask

    // R4: beam-mode mask taken only at cycle start
    task automatic t_mask();
        start_cycle();
        beam_mode_i = 1'b1;
        fault_i = 4'b0010;
        @(negedge clk);
        chk("R4 mask unchanged without start", 32'(trip_valid_o), 1);
        fault_i = '0;
        @(negedge clk);
        rearm();
        start_cycle();
        fault_i = 4'b1010;
        @(negedge clk);
        chk("R4 disabled no trip", 32'(trip_valid_o), 0);
        chk("R4 disabled no status", 32'(fault_active_o), 0);
        chk("R4 disabled auto kept", 32'(permit_auto_o), 1);
        chk("R4 disabled latch kept", 32'(permit_latch_o), 1);
        fault_i = 4'b1110;
        @(negedge clk);
        chk("R4 enabled input trips", 32'(trip_vec_o), 32'b000100);
        fault_i = '0;
        beam_mode_i = 1'b0;
        @(negedge clk);
        start_cycle();
        rearm();
    endtask

    // R6: link timestamp step check
    task automatic t_link();
        start_cycle();
        link_time_valid_i = 1'b1;
        link_time_i = 16'd100;
        @(negedge clk);
        link_time_i = 16'd102;
        @(negedge clk);
        chk("R6 good step", 32'(ts_fault_o), 0);
        link_time_i = 16'd102;
        @(negedge clk);
        link_time_valid_i = 1'b0;
        chk("R6 zero step flagged", 32'(ts_fault_o), 1);
        @(negedge clk);
        chk("R6 ts trip event", 32'(trip_vec_o), 32'b100000);
        link_time_valid_i = 1'b1;
        link_time_i = 16'd107;
        @(negedge clk);
        chk("R6 step above max flagged", 32'(ts_fault_o), 1);
        link_time_i = 16'd111;
        @(negedge clk);
        link_time_valid_i = 1'b0;
        chk("R6 max step clears", 32'(ts_fault_o), 0);
        rearm();
        chk("R8 latch up after ts clears", 32'(permit_latch_o), 1);
    endtask

    // R5 R10: missing heartbeat, saturated trip time
    task automatic t_heartbeat();
        start_cycle();
        repeat (999) @(negedge clk);
        chk("R5 no fault before limit", 32'(hb_fault_o), 0);
        @(negedge clk);
        chk("R5 fault at limit", 32'(hb_fault_o), 1);
        @(negedge clk);
        chk("R5 hb trip event", 32'(trip_vec_o), 32'b010000);
        chk("R10 time saturated", 32'(trip_time_o), 255);
        start_cycle();
        chk("R5 start clears", 32'(hb_fault_o), 0);
        rearm();
        chk("R8 latch up after hb clears", 32'(permit_latch_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_trip_time();
        t_first();
        t_holdoff();
        t_mask();
        t_link();
        t_heartbeat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule